// File: doc/BRIEF.md
# Stride-Based Fault Address Predictor

This block observes a stream of page-fault addresses and produces, for each one, the page number that is most likely to fault next. A prefetch engine downstream can use that page number as a hint. The block keeps the most recent past fault addresses in a short shift register and compares the gaps between consecutive addresses. When the most recent gaps agree and are not zero, the hint is the current address advanced by that gap. In every other case the hint is the page that directly follows the current one.

Faults enter through a valid/ready port. Hints leave through a valid/ready port with one register stage. A fault is accepted only when the hint register is empty, or when its content is consumed in the same cycle. A stalled hint consumer therefore holds back the fault stream. Nothing is lost and nothing is overwritten. The block does not issue the prefetch, check whether a page is present, or access memory.

Top module: `stride_fault_predictor`

## Requirements
- R1: `flt_ready` is high exactly when `hint_valid` is low or `hint_ready` is high. A fault is accepted on a rising clock edge where `flt_valid` and `flt_ready` are both high. While `hint_valid` is high and `hint_ready` is low, no fault is accepted.
- R2: `hint_valid` rises on the clock edge that accepts a fault. It falls on the next edge where `hint_ready` is high, unless that edge accepts another fault.
- R3: While `hint_valid` is high and `hint_ready` is low, `hint_page` and `hint_valid` hold their values.
- R4: When fewer than three addresses have been recorded, counting the current one, the hint is the sequential page.
- R5: When three addresses have been recorded, a stride is detected if the two gaps between them are equal. The stride is that common gap.
- R6: When four or more addresses have been recorded, a stride is detected only if the last three gaps are all equal. A mismatch in any of those three gaps gives the sequential page.
- R7: When a stride is detected, the hint is bits 47:12 of (current address + stride), with the sum taken modulo 2^48.
- R8: Each gap is the newer address minus the older one, in 48-bit two's complement, so negative strides are predicted like positive ones.
- R9: A stride of zero counts as no stride, and the hint is the sequential page.
- R10: The sequential page is bits 47:12 of the current address plus one, taken modulo 2^36.
- R11: An active-low reset clears the recorded history and drives `hint_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_valid | input | 1 | A fault address is offered |
| flt_ready | output | 1 | The block can accept a fault this cycle |
| flt_addr | input | 48 | Byte address of the fault |
| hint_valid | output | 1 | A predicted page number is available |
| hint_ready | input | 1 | The consumer takes the hint this cycle |
| hint_page | output | 36 | Predicted page number (address bits 47:12) |

## Verification
The hardest case to reach is one where a longer history gives a different answer from a shorter one. A run of gaps can match over the last two gaps but not the last three. A stride can also be wiped out by a reset in the middle of a run. The stimulus chains a single address sequence with positive, negative, zero and sub-page strides, so that each new gap breaks or completes the previous run. Three 0x2000 steps placed near the top of the address space make the stride result differ from the sequential result. One reset is placed between the second and third of those steps. A stall with `hint_ready` held low while a fault is offered checks that the hint holds and that the stalled fault is not recorded.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  parameter int unsigned ADDR_W      = 48;
  parameter int unsigned PAGE_SHIFT  = 12;
  parameter int unsigned MATCH_DIFFS = 3;
  localparam int unsigned PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int unsigned MIN_ADDRS  = 3;
  localparam int unsigned CNT_W      = $clog2(MATCH_DIFFS + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PAGE_W-1:0] page_t;
endpackage

// File: rtl/sfp_history.sv
module sfp_history #(
  parameter int unsigned ADDR_W = sfp_pkg::ADDR_W,
  parameter int unsigned DEPTH  = sfp_pkg::MATCH_DIFFS,
  parameter int unsigned CNT_W  = sfp_pkg::CNT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [ADDR_W-1:0]            push_addr,
  output logic [DEPTH-1:0][ADDR_W-1:0] past,
  output logic [CNT_W-1:0]             count
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  // entry 0 is the newest recorded address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) past[0] <= push_addr;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_shift
      always_ff @(posedge clk) begin
        if (push) past[i] <= past[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/sfp_stride_match.sv
module sfp_stride_match #(
  parameter int unsigned ADDR_W    = sfp_pkg::ADDR_W,
  parameter int unsigned DEPTH     = sfp_pkg::MATCH_DIFFS,
  parameter int unsigned CNT_W     = sfp_pkg::CNT_W,
  parameter int unsigned MIN_ADDRS = sfp_pkg::MIN_ADDRS
) (
  input  logic [ADDR_W-1:0]            cur,
  input  logic [DEPTH-1:0][ADDR_W-1:0] past,
  input  logic [CNT_W-1:0]             count,
  output logic                         stride_ok,
  output logic [ADDR_W-1:0]            stride
);
  // gap k lies between the (k)th and (k+1)th newest addresses, the current one counted as newest
  logic [DEPTH-1:0][ADDR_W-1:0] gap;
  logic [DEPTH-1:0]             agree;

  assign gap[0]   = cur - past[0];
  assign agree[0] = 1'b1;

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_gap
      assign gap[k] = past[k-1] - past[k];
      // a gap that has not been recorded yet does not vote
      assign agree[k] = (int'(count) <= k) || (gap[k] == gap[0]);
    end
  endgenerate

  logic enough;
  assign enough    = (int'(count) + 1) >= int'(MIN_ADDRS);
  assign stride    = gap[0];
  assign stride_ok = enough && (&agree) && (gap[0] != '0);
endmodule

// File: rtl/sfp_hint_calc.sv
module sfp_hint_calc #(
  parameter int unsigned ADDR_W     = sfp_pkg::ADDR_W,
  parameter int unsigned PAGE_SHIFT = sfp_pkg::PAGE_SHIFT,
  parameter int unsigned PAGE_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              stride_ok,
  input  logic [ADDR_W-1:0] stride,
  output logic [PAGE_W-1:0] page
);
  logic [ADDR_W-1:0] target;
  logic [PAGE_W-1:0] next_seq;

  assign target   = cur + stride;
  assign next_seq = cur[ADDR_W-1:PAGE_SHIFT] + 1'b1;

  always_comb begin
    if (stride_ok) page = target[ADDR_W-1:PAGE_SHIFT];
    else           page = next_seq;
  end
endmodule

// File: rtl/stride_fault_predictor.sv
module stride_fault_predictor #(
  parameter int unsigned ADDR_W      = sfp_pkg::ADDR_W,
  parameter int unsigned PAGE_SHIFT  = sfp_pkg::PAGE_SHIFT,
  parameter int unsigned MATCH_DIFFS = sfp_pkg::MATCH_DIFFS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flt_valid,
  output logic                     flt_ready,
  input  logic [ADDR_W-1:0]        flt_addr,
  output logic                     hint_valid,
  input  logic                     hint_ready,
  output logic [ADDR_W-PAGE_SHIFT-1:0] hint_page
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int unsigned CNT_W  = $clog2(MATCH_DIFFS + 1);

  logic                               accept;
  logic [MATCH_DIFFS-1:0][ADDR_W-1:0] past;
  logic [CNT_W-1:0]                   count;
  logic                               stride_ok;
  logic [ADDR_W-1:0]                  stride;
  logic [PAGE_W-1:0]                  next_page;

  assign flt_ready = !hint_valid || hint_ready;
  assign accept    = flt_valid && flt_ready;

  sfp_history #(
    .ADDR_W (ADDR_W),
    .DEPTH  (MATCH_DIFFS),
    .CNT_W  (CNT_W)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_addr (flt_addr),
    .past      (past),
    .count     (count)
  );

  sfp_stride_match #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (MATCH_DIFFS),
    .CNT_W     (CNT_W),
    .MIN_ADDRS (sfp_pkg::MIN_ADDRS)
  ) u_match (
    .cur       (flt_addr),
    .past      (past),
    .count     (count),
    .stride_ok (stride_ok),
    .stride    (stride)
  );

  sfp_hint_calc #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .PAGE_W     (PAGE_W)
  ) u_calc (
    .cur       (flt_addr),
    .stride_ok (stride_ok),
    .stride    (stride),
    .page      (next_page)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hint_valid <= 1'b0;
    end else if (accept) begin
      hint_valid <= 1'b1;
    end else if (hint_ready) begin
      hint_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) hint_page <= next_page;
  end
endmodule

// File: rtl/stride_fault_predictor_chk.sv
module stride_fault_predictor_chk #(
  parameter int unsigned PAGE_W = sfp_pkg::PAGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic              flt_ready,
  input logic              hint_valid,
  input logic              hint_ready,
  input logic [PAGE_W-1:0] hint_page
);
  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && !hint_ready) |-> !flt_ready);

  a_r2_hint_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready) |=> hint_valid);

  a_r2_no_spurious_hint: assert property (@(posedge clk) disable iff (!rst_n)
    (!(flt_valid && flt_ready) && (!hint_valid || hint_ready)) |=> !hint_valid);

  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && !hint_ready) |=> (hint_valid && $stable(hint_page)));
endmodule

bind stride_fault_predictor stride_fault_predictor_chk #(
  .PAGE_W (ADDR_W - PAGE_SHIFT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flt_valid  (flt_valid),
  .flt_ready  (flt_ready),
  .hint_valid (hint_valid),
  .hint_ready (hint_ready),
  .hint_page  (hint_page)
);

// File: tb/stride_fault_predictor_tb.sv
module stride_fault_predictor_tb;
  localparam int NV = 17;
  localparam logic [47:0] VA [NV] = '{
    48'h0000_1000_0000, 48'h0000_1000_3000, 48'h0000_1000_6000, 48'h0000_1000_9000,
    48'h0000_1000_A000, 48'h0000_1000_B000, 48'h0000_1000_C000, 48'h0000_1000_8000,
    48'h0000_1000_4000, 48'h0000_1000_0000, 48'h0000_1000_0000, 48'h0000_1000_0000,
    48'h0000_1000_0000, 48'h0000_1000_0800, 48'h0000_1000_1000, 48'h0000_1000_1800,
    48'h0000_1000_2000};
  localparam logic [35:0] VP [NV] = '{
    36'h10001, 36'h10004, 36'h10009, 36'h1000C,
    36'h1000B, 36'h1000C, 36'h1000D, 36'h10009,
    36'h10005, 36'h0FFFC, 36'h10001, 36'h10001,
    36'h10001, 36'h10001, 36'h10002, 36'h10002,
    36'h10002};
  // requirement exercised by each vector
  localparam string VR [NV] = '{
    "R4 R10", "R4", "R5 R7", "R6 R7", "R6", "R6", "R6 R7", "R8 R10",
    "R6", "R8 R7", "R10", "R6", "R9", "R10", "R6", "R7", "R7"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic        flt_ready;
  logic [47:0] flt_addr = '0;
  logic        hint_valid;
  logic        hint_ready = 1'b1;
  logic [35:0] hint_page;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  stride_fault_predictor u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_valid  (flt_valid),
    .flt_ready  (flt_ready),
    .flt_addr   (flt_addr),
    .hint_valid (hint_valid),
    .hint_ready (hint_ready),
    .hint_page  (hint_page)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offer one fault at a falling edge; result is sampled at the next falling edge
  task automatic send(input logic [47:0] a);
    @(negedge clk);
    flt_valid = 1'b1;
    flt_addr  = a;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic send_check(input logic [47:0] a, input logic [35:0] exp, input string req);
    send(a);
    check(hint_valid === 1'b1, {req, " valid"}, 48'(hint_valid), 48'h1);
    check(hint_page === exp, req, 48'(hint_page), 48'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11: reset state
    check(hint_valid === 1'b0, "R11 reset hint_valid", 48'(hint_valid), 48'h0);
    check(flt_ready === 1'b1, "R1 ready while empty", 48'(flt_ready), 48'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send_check(VA[i], VP[i], VR[i]);
    end

    // R2: hint drops once consumed with no new fault
    @(negedge clk);
    check(hint_valid === 1'b0, "R2 drop after consume", 48'(hint_valid), 48'h0);

    // R1/R3: stall the consumer, offer a fault that must not be taken
    hint_ready = 1'b0;
    send_check(48'h0000_2000_0000, 36'h20001, "R3 stall setup");
    flt_valid = 1'b1;
    flt_addr  = 48'h0000_5555_5000;
    repeat (3) begin
      @(negedge clk);
      check(flt_ready === 1'b0, "R1 not ready while stalled", 48'(flt_ready), 48'h0);
      check(hint_page === 36'h20001, "R3 hold page", 48'(hint_page), 48'h20001);
      check(hint_valid === 1'b1, "R3 hold valid", 48'(hint_valid), 48'h1);
    end
    flt_valid = 1'b0;
    hint_ready = 1'b1;
    @(negedge clk);
    check(hint_valid === 1'b0, "R2 drop after release", 48'(hint_valid), 48'h0);
    // stalled fault never recorded: history ends 0x10002000 then 0x20000000
    send_check(48'h0000_2000_0000, 36'h20001, "R1 stalled fault ignored");
    send_check(48'h0000_2000_0000, 36'h20001, "R1 stalled fault ignored zero");

    // R11: reset wipes history mid-run; R7 wrap at top of address space
    do_reset();
    check(hint_valid === 1'b0, "R11 reset clears valid", 48'(hint_valid), 48'h0);
    send_check(48'hFFFF_FFFF_B000, 36'hFFFFFFFFC, "R4 top first");
    send_check(48'hFFFF_FFFF_D000, 36'hFFFFFFFFE, "R4 top second");
    do_reset();
    send_check(48'hFFFF_FFFF_F000, 36'h000000000, "R11 history cleared R10 wrap");
    do_reset();
    send_check(48'hFFFF_FFFF_B000, 36'hFFFFFFFFC, "R4 again");
    send_check(48'hFFFF_FFFF_D000, 36'hFFFFFFFFE, "R4 again second");
    send_check(48'hFFFF_FFFF_F000, 36'h000000001, "R5 R7 stride wraps");

    // R2: back-to-back accepts keep the hint valid
    @(negedge clk);
    flt_valid = 1'b1;
    flt_addr  = 48'h0000_3000_0000;
    @(negedge clk);
    check(hint_valid === 1'b1, "R2 b2b first", 48'(hint_valid), 48'h1);
    flt_addr  = 48'h0000_3000_4000;
    @(negedge clk);
    flt_valid = 1'b0;
    check(hint_page === 36'h30005, "R2 b2b second", 48'(hint_page), 48'h30005);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule